// File: doc/BRIEF.md
# Posted-Write Direct-Mapped Accelerator Cache

This block sits between a fast 8-bit processor core and a slow system memory bus. It uses a 16-bit address space and holds 8 KB of data. A load that finds its line present completes in the same cycle. A load that misses holds the core while the block reads the whole 4-byte line over the slow bus, one byte at a time, marks the line valid and then completes from the cache.

Stores use a write-through policy. Each store goes into a one-byte posted buffer. That buffer drains to system memory in the background, so system memory always holds the latest value. If the stored byte's line is already cached, the cached copy is updated as well. A store that misses leaves the cache untouched.

The core is held in only two cases: a load miss is being serviced, or a store arrives while the posted byte has not yet left. A load miss never starts its line read while a store is still posted, so memory sees accesses in program order.

Top module: `posted_wt_cache`

## Requirements
- R1: A synchronous reset (`rst` high) invalidates every line and empties the posted buffer. After reset, `bus_req` is low, and a load to a line that was cached before the reset misses again.
- R2: A load miss with an empty posted buffer issues four bus reads to the line's bytes, with the address bits [1:0] counting 0 to 3. It asserts `cpu_ready` 33 cycles after the load is first presented, with the requested byte on `cpu_rdata`. While the load misses, `cpu_ready` stays low.
- R3: A load to a valid line whose tag (address bits [15:13]) matches asserts `cpu_ready` in the same cycle with the correct byte. This holds for every byte offset (bits [1:0]) of the line.
- R4: The line index is address bits [12:2]. Two addresses whose low 13 bits are equal share one line. Loading one of them evicts the other.
- R5: Every store, hit or miss, produces exactly one bus write (`bus_we` high) with the store's address and data. A store that finds the buffer empty is accepted in the cycle it is presented, and the buffer is occupied in the next cycle.
- R6: A store that hits updates the cached byte. A following load of that byte hits with zero wait and returns the new value.
- R7: A store that misses does not allocate a line. A later load of that address misses, and it returns the stored value from memory.
- R8: A store presented while the posted byte is still waiting is held. It is accepted in the cycle in which the bus acknowledges the posted byte. Back-to-back stores against an 8-cycle bus are therefore accepted every 8 cycles.
- R9: A load miss that finds a byte still posted does not issue a bus read until that byte is written. A load miss presented right after a store completes after 41 cycles and observes the stored value.
- R10: Once `bus_req` is raised, it stays high with `bus_addr`, `bus_we` and `bus_wdata` unchanged until the cycle in which `bus_ack` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Core access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 16 | Core byte address |
| cpu_wdata | input | 8 | Store data |
| cpu_rdata | output | 8 | Load data, valid when `cpu_ready` is high on a load |
| cpu_ready | output | 1 | Access completes at the next clock edge |
| bus_req | output | 1 | Slow bus request, held until acknowledged |
| bus_we | output | 1 | 1 = bus write of the posted byte, 0 = line-fill read |
| bus_addr | output | 16 | Slow bus byte address |
| bus_wdata | output | 8 | Slow bus write data |
| bus_rdata | input | 8 | Slow bus read data, valid with `bus_ack` |
| bus_ack | input | 1 | One-cycle completion of the current bus access |

## Verification
The checker watches the cycle-level rules on every clock:
- the bus request stays held and unchanged until it is acknowledged;
- no fill read is issued while a byte is posted;
- a store is held while the buffer is occupied and no acknowledge has arrived;
- a load miss never reports ready;
- every accepted store shows up as a bus write in the next cycle.

Only the bench's scenarios can show the rest, because each depends on a sequence of accesses and on data values:
- the exact stall counts of 0, 7, 33 and 41 cycles;
- eviction between aliasing addresses;
- no-allocate on a store miss;
- hit updates;
- read-after-write ordering through memory;
- invalidation by reset.

// File: rtl/pwc_pkg.sv
`timescale 1ns/1ps
package pwc_pkg;
    localparam int ADDR_W      = 16;
    localparam int BYTE_W      = 8;
    localparam int CACHE_BYTES = 8192;
    localparam int LINE_BYTES  = 4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } fsm_e;
endpackage

// File: rtl/pwc_line_store.sv
`timescale 1ns/1ps
module pwc_line_store #(
    parameter int IDX_W  = 11,
    parameter int TAG_W  = 3,
    parameter int OFF_W  = 2,
    parameter int BYTE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [IDX_W-1:0]              rd_idx,
    output logic [TAG_W-1:0]              rd_tag,
    output logic                          rd_valid,
    output logic [(BYTE_W<<OFF_W)-1:0]    rd_line,
    input  logic                          byte_we,
    input  logic [IDX_W-1:0]              byte_idx,
    input  logic [OFF_W-1:0]              byte_off,
    input  logic [BYTE_W-1:0]             byte_data,
    input  logic                          fill_we,
    input  logic [IDX_W-1:0]              fill_idx,
    input  logic [TAG_W-1:0]              fill_tag,
    input  logic [(BYTE_W<<OFF_W)-1:0]    fill_line
);
    localparam int LINES  = 1 << IDX_W;
    localparam int LINE_W = BYTE_W << OFF_W;

    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [LINE_W-1:0] data_q [LINES];

    // Valid bits are the only state that reset touches.
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (fill_we) begin
            valid_q[fill_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_we) begin
            tag_q[fill_idx]  <= fill_tag;
            data_q[fill_idx] <= fill_line;
        end else if (byte_we) begin
            data_q[byte_idx][byte_off*BYTE_W +: BYTE_W] <= byte_data;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_line  = data_q[rd_idx];
endmodule

// File: rtl/pwc_post_buf.sv
`timescale 1ns/1ps
module pwc_post_buf #(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [BYTE_W-1:0] push_data,
    input  logic              pop,
    output logic              full,
    output logic [ADDR_W-1:0] addr,
    output logic [BYTE_W-1:0] data
);
    typedef struct packed {
        logic              full;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;

    // A push in the same cycle as a pop refills the slot.
    always_comb begin
        slot_d = slot_q;
        if (push) begin
            slot_d.full = 1'b1;
            slot_d.addr = push_addr;
            slot_d.data = push_data;
        end else if (pop) begin
            slot_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_d;
    end

    assign full = slot_q.full;
    assign addr = slot_q.addr;
    assign data = slot_q.data;
endmodule

// File: rtl/posted_wt_cache.sv
`timescale 1ns/1ps
module posted_wt_cache
    import pwc_pkg::*;
#(
    parameter int ADDR_W      = pwc_pkg::ADDR_W,
    parameter int BYTE_W      = pwc_pkg::BYTE_W,
    parameter int CACHE_BYTES = pwc_pkg::CACHE_BYTES,
    parameter int LINE_BYTES  = pwc_pkg::LINE_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic [BYTE_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BYTE_W-1:0] bus_wdata,
    input  logic [BYTE_W-1:0] bus_rdata,
    input  logic              bus_ack
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int LINES  = CACHE_BYTES / LINE_BYTES;
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = LINE_BYTES * BYTE_W;
    localparam int LAST   = LINE_BYTES - 1;

    typedef struct packed {
        fsm_e              st;
        logic [OFF_W-1:0]  cnt;
        logic [LINE_W-1:0] line;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [TAG_W-1:0]  cpu_tag, rd_tag;
    logic [IDX_W-1:0]  cpu_idx;
    logic [OFF_W-1:0]  cpu_off;
    logic [LINE_W-1:0] rd_line;
    logic              rd_valid, hit;
    logic              wb_full, drain, wb_pop, store_ok, push, filling, fill_we;
    logic [ADDR_W-1:0] wb_addr;
    logic [BYTE_W-1:0] wb_data;

    assign cpu_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign cpu_idx = cpu_addr[OFF_W +: IDX_W];
    assign cpu_off = cpu_addr[OFF_W-1:0];
    assign hit     = rd_valid && (rd_tag == cpu_tag);

    // Bus ownership: the posted byte drains whenever no fill is running.
    assign filling   = (ctl_q.st == ST_FILL);
    assign drain     = wb_full && !filling;
    assign wb_pop    = drain && bus_ack;
    assign store_ok  = !wb_full || wb_pop;
    assign bus_req   = drain || filling;
    assign bus_we    = !filling;
    assign bus_addr  = filling ? {cpu_tag, cpu_idx, ctl_q.cnt} : wb_addr;
    assign bus_wdata = wb_data;

    assign cpu_ready = !filling && (cpu_we ? store_ok : hit);
    assign cpu_rdata = rd_line[cpu_off*BYTE_W +: BYTE_W];
    assign push      = cpu_req && cpu_we && cpu_ready;

    always_comb begin
        ctl_d   = ctl_q;
        fill_we = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                // A miss waits for the posted byte to leave first.
                if (cpu_req && !cpu_we && !hit && !wb_full) begin
                    ctl_d.st  = ST_FILL;
                    ctl_d.cnt = '0;
                end
            end
            ST_FILL: begin
                if (bus_ack) begin
                    ctl_d.line[ctl_q.cnt*BYTE_W +: BYTE_W] = bus_rdata;
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == OFF_W'(LAST)) begin
                        ctl_d.st = ST_IDLE;
                        fill_we  = 1'b1;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    pwc_line_store #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .OFF_W (OFF_W),
        .BYTE_W(BYTE_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (cpu_idx),
        .rd_tag   (rd_tag),
        .rd_valid (rd_valid),
        .rd_line  (rd_line),
        .byte_we  (push && hit),
        .byte_idx (cpu_idx),
        .byte_off (cpu_off),
        .byte_data(cpu_wdata),
        .fill_we  (fill_we),
        .fill_idx (cpu_idx),
        .fill_tag (cpu_tag),
        .fill_line(ctl_d.line)
    );

    pwc_post_buf #(
        .ADDR_W(ADDR_W),
        .BYTE_W(BYTE_W)
    ) u_post (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_addr(cpu_addr),
        .push_data(cpu_wdata),
        .pop      (wb_pop),
        .full     (wb_full),
        .addr     (wb_addr),
        .data     (wb_data)
    );
endmodule

// File: rtl/pwc_checker.sv
`timescale 1ns/1ps
module pwc_checker #(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              cpu_ready,
    input logic              bus_req,
    input logic              bus_we,
    input logic              bus_ack,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic              wb_full,
    input logic              hit
);
    p_bus_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    p_fill_after_drain_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we) |-> !wb_full);

    p_store_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && wb_full && !bus_ack) |-> !cpu_ready);

    p_miss_stall_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_we && !hit) |-> !cpu_ready);

    p_store_posted_r5: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && cpu_ready) |=> (wb_full && bus_req && bus_we));
endmodule

bind posted_wt_cache pwc_checker #(
    .ADDR_W(ADDR_W),
    .BYTE_W(BYTE_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cpu_req  (cpu_req),
    .cpu_we   (cpu_we),
    .cpu_ready(cpu_ready),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_ack  (bus_ack),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .wb_full  (wb_full),
    .hit      (hit)
);

// File: tb/posted_wt_cache_tb.sv
`timescale 1ns/1ps
module posted_wt_cache_tb;
    localparam int LAT = 8;
    localparam int NV  = 12;
    // {we, addr, wdata, expected rdata, expected wait cycles}
    localparam logic [40:0] VEC [NV] = '{
        {1'b0, 16'h1234, 8'h00, 8'h26, 8'd33},
        {1'b0, 16'h1235, 8'h00, 8'h27, 8'd0},
        {1'b0, 16'h1237, 8'h00, 8'h25, 8'd0},
        {1'b1, 16'h1236, 8'hA5, 8'h00, 8'd0},
        {1'b0, 16'h1236, 8'h00, 8'hA5, 8'd0},
        {1'b0, 16'h3234, 8'h00, 8'h06, 8'd33},
        {1'b0, 16'h1236, 8'h00, 8'hA5, 8'd33},
        {1'b1, 16'h4000, 8'h3C, 8'h00, 8'd0},
        {1'b0, 16'h4000, 8'h00, 8'h3C, 8'd33},
        {1'b0, 16'h1FFF, 8'h00, 8'hE0, 8'd33},
        {1'b0, 16'h1FFC, 8'h00, 8'hE3, 8'd0},
        {1'b0, 16'hFFFF, 8'h00, 8'h00, 8'd33}
    };
    string VTAG [NV] = '{"R2", "R3", "R3", "R6", "R6", "R4",
                         "R5", "R7", "R7", "R2", "R3", "R4"};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_ready;
    logic        bus_req, bus_we, bus_ack;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;

    int n_chk = 0, n_fail = 0;
    int op_waits;
    logic [7:0] op_rdata;
    int wr_cnt = 0;
    logic [15:0] last_wr_addr = '0;
    logic [7:0]  last_wr_data = '0;
    int lat_cnt = 0;
    logic [7:0] mem [logic [15:0]];

    always #4 clk = ~clk;

    posted_wt_cache u_dut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    function automatic logic [7:0] mem_rd(input logic [15:0] a);
        if (mem.exists(a)) return mem[a];
        return a[15:8] ^ a[7:0];
    endfunction

    // Slow memory: each access acknowledged in its 8th request cycle.
    always @(posedge clk) begin
        if (rst) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
            lat_cnt   <= 0;
        end else if (bus_ack) begin
            bus_ack <= 1'b0;
            lat_cnt <= 0;
            if (bus_we) begin
                mem[bus_addr] = bus_wdata;
                wr_cnt        = wr_cnt + 1;
                last_wr_addr  = bus_addr;
                last_wr_data  = bus_wdata;
            end
        end else if (bus_req) begin
            if (lat_cnt == LAT - 2) begin
                bus_ack   <= 1'b1;
                bus_rdata <= mem_rd(bus_addr);
            end
            lat_cnt <= lat_cnt + 1;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Presents one access at a negedge, counts negedges until ready.
    task automatic do_op(input logic we, input logic [15:0] a, input logic [7:0] d);
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_addr  = a;
        cpu_wdata = d;
        #1;
        op_waits = 0;
        while (!cpu_ready && op_waits < 300) begin
            @(negedge clk);
            #1;
            op_waits++;
        end
        op_rdata = cpu_rdata;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        cpu_req = 1'b0;
        cpu_we  = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int wbase;
        repeat (3) @(negedge clk);
        // R1: state right after reset
        check("R1 bus_req in reset", int'(bus_req), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 bus_req after reset", int'(bus_req), 0);

        for (int i = 0; i < NV; i++) begin
            wbase = wr_cnt;
            do_op(VEC[i][40], VEC[i][39:24], VEC[i][23:16]);
            idle(12);
            check({VTAG[i], " waits"}, op_waits, int'(VEC[i][7:0]));
            if (VEC[i][40]) begin
                check("R5 one bus write", wr_cnt - wbase, 1);
                check("R5 write addr", int'(last_wr_addr), int'(VEC[i][39:24]));
                check("R5 write data", int'(last_wr_data), int'(VEC[i][23:16]));
            end else begin
                check({VTAG[i], " data"}, int'(op_rdata), int'(VEC[i][15:8]));
            end
        end

        // R8: back-to-back stores accepted every 8 cycles
        wbase = wr_cnt;
        do_op(1'b1, 16'h0100, 8'h11);
        check("R8 first store waits", op_waits, 0);
        do_op(1'b1, 16'h0101, 8'h22);
        check("R8 second store waits", op_waits, 7);
        do_op(1'b1, 16'h0102, 8'h33);
        check("R8 third store waits", op_waits, 7);
        idle(12);
        check("R8 writes drained", wr_cnt - wbase, 3);
        check("R8 last write data", int'(last_wr_data), 8'h33);

        // R9: load miss right after a store waits for the drain
        do_op(1'b1, 16'h0500, 8'h77);
        do_op(1'b0, 16'h0500, 8'h00);
        idle(4);
        check("R9 miss after store waits", op_waits, 41);
        check("R9 miss after store data", int'(op_rdata), 8'h77);

        // R1: reset invalidates a cached line
        do_op(1'b0, 16'h1235, 8'h00);
        idle(2);
        check("R3 line cached before reset", op_waits, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 bus idle after reset", int'(bus_req), 0);
        do_op(1'b0, 16'h1235, 8'h00);
        idle(2);
        check("R1 miss after reset waits", op_waits, 33);
        check("R1 miss after reset data", int'(op_rdata), 8'h27);

        summary();
        $finish;
    end
endmodule